// File: doc/BRIEF.md
# SHA-512 Two-Round Compression Step

This unit advances the SHA-512 compression function by two rounds per invocation. The eight 64-bit working variables come in split across two 256-bit vectors. One vector carries the "leading" half (A, B, E, F). The other carries the "trailing" half (C, D, G, H). A third, 128-bit input supplies the two round addends. Each addend is a message word already summed with its round constant. The unit returns only the new leading half.

After two rounds, the trailing half is exactly the leading half that went in. A caller that drives a full 80-round block keeps the previous leading vector and passes it as the next trailing vector. It then chains 40 invocations and adds the result to the running hash.

Inputs are taken with a valid/ready handshake. The two rounds run on one shared round datapath in two clock cycles. The result is then held until the consumer takes it.

Top module: `sha512r_top`

## Requirements
- R1: `lead_in` bits [255:192] carry A, [191:128] B, [127:64] E and [63:0] F. `trail_in` bits [255:192] carry C, [191:128] D, [127:64] G and [63:0] H.
- R2: Each round forms T = Ch(E,F,G) + Sigma1(E) + addend + H. New A = T + Maj(A,B,C) + Sigma0(A), and new E = T + D. The other variables shift: B takes A, C takes B, D takes C, F takes E, G takes F and H takes G.
- R3: `addend_in` bits [63:0] feed the first round and bits [127:64] feed the second round.
- R4: Sigma0 is the XOR of right-rotations by 28, 34 and 39. Sigma1 is the XOR of right-rotations by 14, 18 and 41. Ch(e,f,g) = (e AND f) XOR (NOT e AND g). Maj(a,b,c) = (a AND b) XOR (a AND c) XOR (b AND c). Every addition wraps modulo 2^64.
- R5: `lead_out` bits [255:192] give A after two rounds, [191:128] B, [127:64] E and [63:0] F.
- R6: A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. `out_valid` is low after that edge and high after the following edge, so the compute takes two cycles.
- R7: From acceptance until the result is taken, `in_ready` is low. Any input presented in that window, valid or not, has no effect on the result.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `lead_out` stays unchanged.
- R9: After an edge with `out_valid` and `out_ready` both high, `out_valid` is low and `in_ready` is high.
- R10: A synchronous active-high `rst` returns the unit to idle on the next edge, with `in_ready` high and `out_valid` low. Any request in progress is dropped and no result appears later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle, request can be taken |
| lead_in | input | 256 | A, B, E, F (qword 3..0) |
| trail_in | input | 256 | C, D, G, H (qword 3..0) |
| addend_in | input | 128 | Round addends, low qword used first |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| lead_out | output | 256 | New A, B, E, F (qword 3..0) |

## Verification
A single invocation exercises only a narrow band of operand values. Carries through every adder position, and every rotation amount feeding the next round, are hard to reach from hand-picked vectors. The stimulus therefore drives complete SHA-512 blocks: 40 chained invocations per block, with the schedule and round constants computed in the bench. The empty message and the three-byte message "abc" are used, and the final digests are compared with the well-known values. Every invocation is also checked against an independent two-round model. During the busy window the bench drives inverted data with valid held high, and it varies consumer stalls, so the ignore rule and the hold rule are checked while real data flows.

// File: rtl/sha512r_pkg.sv
package sha512r_pkg;
  localparam int WORD_W = 64;
  localparam int LANES  = 4;
  localparam int VEC_W  = WORD_W * LANES;
  localparam int ADD_W  = WORD_W * 2;
  localparam int BS0_A = 28, BS0_B = 34, BS0_C = 39;
  localparam int BS1_A = 14, BS1_B = 18, BS1_C = 41;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t a, b, c, d, e, f, g, h;
  } wvars_t;

  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_RND2 = 2'd1, PH_HOLD = 2'd2} phase_t;

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t bsig0(input word_t x);
    return rotr(x, BS0_A) ^ rotr(x, BS0_B) ^ rotr(x, BS0_C);
  endfunction

  function automatic word_t bsig1(input word_t x);
    return rotr(x, BS1_A) ^ rotr(x, BS1_B) ^ rotr(x, BS1_C);
  endfunction

  function automatic word_t choose(input word_t e, input word_t f, input word_t g);
    return (e & f) ^ (~e & g);
  endfunction

  function automatic word_t majority(input word_t a, input word_t b, input word_t c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction

  function automatic wvars_t one_round(input wvars_t s, input word_t addend);
    wvars_t n;
    word_t  t;
    t   = choose(s.e, s.f, s.g) + bsig1(s.e) + addend + s.h;
    n.a = t + majority(s.a, s.b, s.c) + bsig0(s.a);
    n.b = s.a;
    n.c = s.b;
    n.d = s.c;
    n.e = t + s.d;
    n.f = s.e;
    n.g = s.f;
    n.h = s.g;
    return n;
  endfunction
endpackage

// File: rtl/sha512r_round.sv
module sha512r_round
  import sha512r_pkg::*;
(
  input  wvars_t cur,
  input  word_t  addend,
  output wvars_t nxt
);
  assign nxt = one_round(cur, addend);
endmodule

// File: rtl/sha512r_ctrl.sv
module sha512r_ctrl
  import sha512r_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic accept_fire,
  output logic rnd2_fire,
  output logic take_fire
);
  phase_t ph;

  assign in_ready    = (ph == PH_IDLE);
  assign out_valid   = (ph == PH_HOLD);
  assign rnd2_fire   = (ph == PH_RND2);
  assign accept_fire = in_valid && in_ready;
  assign take_fire   = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE;
    end else begin
      case (ph)
        PH_IDLE: if (accept_fire) ph <= PH_RND2;
        PH_RND2: ph <= PH_HOLD;
        PH_HOLD: if (out_ready) ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R10
  rst_idle_chk: assert property (@(posedge clk) rst |=> (in_ready && !out_valid));
  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    accept_fire |=> (!in_ready && !out_valid && rnd2_fire));
  // R6
  two_cycle_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rnd2_fire |=> out_valid);
  // R8
  hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid);
  // R9
  free_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    take_fire |=> (in_ready && !out_valid));
  // R7
  phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({in_ready, rnd2_fire, out_valid}));
endmodule

// File: rtl/sha512r_top.sv
module sha512r_top
  import sha512r_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] lead_in,
  input  logic [VEC_W-1:0] trail_in,
  input  logic [ADD_W-1:0] addend_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] lead_out
);
  word_t  lead_w [LANES];
  word_t  trail_w[LANES];
  wvars_t in_vars, st, rnd_in, rnd_out;
  word_t  addend_hi, rnd_addend;
  logic   accept_fire, rnd2_fire, take_fire;

  for (genvar i = 0; i < LANES; i++) begin : g_unpack
    assign lead_w[i]  = lead_in [i*WORD_W +: WORD_W];
    assign trail_w[i] = trail_in[i*WORD_W +: WORD_W];
  end

  assign in_vars = '{a: lead_w[3],  b: lead_w[2],  c: trail_w[3], d: trail_w[2],
                     e: lead_w[1],  f: lead_w[0],  g: trail_w[1], h: trail_w[0]};

  sha512r_ctrl u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .accept_fire(accept_fire),
    .rnd2_fire(rnd2_fire), .take_fire(take_fire)
  );

  assign rnd_in     = accept_fire ? in_vars : st;
  assign rnd_addend = accept_fire ? addend_in[WORD_W-1:0] : addend_hi;

  sha512r_round u_round (.cur(rnd_in), .addend(rnd_addend), .nxt(rnd_out));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= '0;
      addend_hi <= '0;
    end else begin
      if (accept_fire || rnd2_fire) st <= rnd_out;
      if (accept_fire) addend_hi <= addend_in[ADD_W-1:WORD_W];
    end
  end

  assign lead_out = {st.a, st.b, st.e, st.f};

  // R8
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(lead_out));
  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !take_fire) |=> $stable(st));
endmodule

// File: tb/sha512r_top_tb_top.sv
module sha512r_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [255:0] lead_in = '0, trail_in = '0, lead_out;
  logic [127:0] addend_in = '0;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sha512r_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .lead_in(lead_in), .trail_in(trail_in), .addend_in(addend_in),
    .out_valid(out_valid), .out_ready(out_ready), .lead_out(lead_out)
  );

  logic [63:0] kc[80];
  logic [63:0] h0[8];

  function automatic logic [63:0] rr(input logic [63:0] x, input int n);
    logic [127:0] d;
    d = {x, x} >> n;
    return d[63:0];
  endfunction

  function automatic logic [63:0] frac_root(input int p, input bit cube);
    logic [255:0] tgt, x, c, pw;
    tgt = cube ? (256'(p) << 192) : (256'(p) << 128);
    x = '0;
    for (int b = 66; b >= 0; b--) begin
      c  = x | (256'(1) << b);
      pw = cube ? c * c * c : c * c;
      if (pw <= tgt) x = c;
    end
    return x[63:0];
  endfunction

  // two reference rounds on v = {a,b,c,d,e,f,g,h} as v[0..7]
  function automatic void ref_two(ref logic [63:0] v[8], input logic [63:0] k0, input logic [63:0] k1);
    logic [63:0] t, na, ne, kk;
    for (int r = 0; r < 2; r++) begin
      kk = (r == 0) ? k0 : k1;
      t  = v[7] + (rr(v[4],14) ^ rr(v[4],18) ^ rr(v[4],41))
                + ((v[4] & v[5]) | (~v[4] & v[6])) + kk;
      na = t + (rr(v[0],28) ^ rr(v[0],34) ^ rr(v[0],39))
             + ((v[0] & v[1]) | (v[2] & (v[0] | v[1])));
      ne = v[3] + t;
      for (int j = 7; j > 0; j--) v[j] = v[j-1];
      v[0] = na;
      v[4] = ne;
    end
  endfunction

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic invoke(input logic [255:0] ld, input logic [255:0] tr, input logic [127:0] ad,
                        input int stall, output logic [255:0] res);
    logic [255:0] first;
    chk(in_ready && !out_valid, "R9 idle before request", {in_ready, out_valid}, 2'b10);
    lead_in = ld; trail_in = tr; addend_in = ad; in_valid = 1'b1; out_ready = 1'b0;
    tick();
    chk(!in_ready && !out_valid, "R7 busy after accept", {in_ready, out_valid}, 2'b00);
    lead_in = ~ld; trail_in = ~tr; addend_in = ~ad;  // R7: must be ignored
    tick();
    chk(out_valid, "R6 result after two cycles", out_valid, 1'b1);
    in_valid = 1'b0;
    first = lead_out;
    for (int s = 0; s < stall; s++) begin
      tick();
      chk(out_valid && lead_out == first, "R8 held during stall", lead_out, first);
    end
    out_ready = 1'b1;
    res = lead_out;
    tick();
    out_ready = 1'b0;
    chk(in_ready && !out_valid, "R9 free after take", {in_ready, out_valid}, 2'b10);
  endtask

  task automatic run_block(input logic [63:0] blk[16], input logic [511:0] digest_exp, input string tag);
    logic [63:0] w[80], v[8], hs[8];
    logic [255:0] ld, tr, res, exp_ld;
    logic [511:0] dg;
    for (int t = 0; t < 16; t++) w[t] = blk[t];
    for (int t = 16; t < 80; t++)
      w[t] = w[t-16] + w[t-7]
           + (rr(w[t-15],1) ^ rr(w[t-15],8) ^ (w[t-15] >> 7))
           + (rr(w[t-2],19) ^ rr(w[t-2],61) ^ (w[t-2] >> 6));
    for (int j = 0; j < 8; j++) hs[j] = h0[j];
    ld = {hs[0], hs[1], hs[4], hs[5]};
    tr = {hs[2], hs[3], hs[6], hs[7]};
    for (int i = 0; i < 40; i++) begin
      v[0] = ld[255:192]; v[1] = ld[191:128]; v[4] = ld[127:64]; v[5] = ld[63:0];
      v[2] = tr[255:192]; v[3] = tr[191:128]; v[6] = tr[127:64]; v[7] = tr[63:0];
      ref_two(v, w[2*i] + kc[2*i], w[2*i+1] + kc[2*i+1]);
      exp_ld = {v[0], v[1], v[4], v[5]};
      invoke(ld, tr, {w[2*i+1] + kc[2*i+1], w[2*i] + kc[2*i]}, i % 3, res);
      // R1 R2 R3 R4 R5
      chk(res == exp_ld, "R2/R5 two-round result", res, exp_ld);
      tr = ld;
      ld = res;
    end
    dg = {hs[0] + ld[255:192], hs[1] + ld[191:128], hs[2] + tr[255:192], hs[3] + tr[191:128],
          hs[4] + ld[127:64],  hs[5] + ld[63:0],    hs[6] + tr[127:64],  hs[7] + tr[63:0]};
    chk(dg == digest_exp, {"R1/R4 digest ", tag}, dg, digest_exp);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] blk[16];
    logic [255:0] dummy;
    int cnt, p;
    bit prime;
    cnt = 0; p = 2;
    while (cnt < 80) begin
      prime = 1;
      for (int d = 2; d * d <= p; d++) if (p % d == 0) prime = 0;
      if (prime) begin
        kc[cnt] = frac_root(p, 1'b1);
        if (cnt < 8) h0[cnt] = frac_root(p, 1'b0);
        cnt++;
      end
      p++;
    end

    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    // R10 reset state
    chk(in_ready && !out_valid, "R10 reset state", {in_ready, out_valid}, 2'b10);

    for (int t = 0; t < 16; t++) blk[t] = '0;
    blk[0] = 64'h8000000000000000;
    run_block(blk, 512'hcf83e1357eefb8bdf1542850d66d8007d620e4050b5715dc83f4a921d36ce9ce47d0d13c5d85f2b0ff8318d2877eec2f63b931bd47417a81a538327af927da3e, "empty");

    blk[0] = 64'h6162638000000000;
    blk[15] = 64'd24;
    run_block(blk, 512'hddaf35a193617abacc417349ae20413112e6fa4e89a97ea20a9eeee64b55d39a2192992a274fc1a836ba3c23a3feebbd454d4423643ce80e2a9ac94fa54ca49f, "abc");

    // R10 reset during compute drops the request
    lead_in = '1; trail_in = '1; addend_in = '1; in_valid = 1'b1;
    tick();
    in_valid = 1'b0;
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk(in_ready && !out_valid, "R10 idle after mid reset", {in_ready, out_valid}, 2'b10);
    for (int s = 0; s < 3; s++) begin
      tick();
      chk(!out_valid, "R10 no pending result", out_valid, 1'b0);
    end
    invoke('0, '0, 128'h1_0000000000000000, 0, dummy);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule